// File: doc/BRIEF.md
# Block Copy and Fill Engine

This engine moves a run of 16-bit words from one memory range to another, or writes one constant into every word of a destination range. It is started with three operands: for copy, the address just below the first source word; for fill, the value to store. The other two are the address of the last destination word and the word count given as a negative number. The first destination address follows from these as last + (negative count) + 1. Words are handled one at a time through a single-request memory port with a grant and a separate read-data strobe. There is never more than one request outstanding.

The run is cut into groups. The first group holds the count modulo 16 words, and may hold none. Every later group holds exactly 16 words. At the start of each group except the final one, the engine emits prefetch hints for addresses 32 words past the current pointers. Between groups it samples an interrupt input. If the interrupt is taken, it stops and reports restartable operands. Feeding those operands back as a new start finishes the transfer.

Top module: `blk_mover`

## Requirements
- R1: Words are written to ascending addresses. The first write goes to arg_last + arg_negcnt + 1 (16-bit wrap). In copy mode the first read comes from arg_src + 1.
- R2: In copy mode each destination word receives the matching source word. The read of a word completes (rvalid) before that word's write is requested.
- R3: In fill mode every destination word receives arg_src. No reads are made.
- R4: The first group transfers (-arg_negcnt) mod 16 words, and every later group transfers 16 words.
- R5: A prefetch hint is issued at the start of each group that is not the final one. The final group issues none. In copy mode there are two hints: first the source pointer + 32, then the destination pointer + 32. Fill mode issues only the destination hint. pf_valid is high only while busy.
- R6: When irq_pend is high at the end of a group that leaves words remaining, the engine stops with a one-cycle yielded pulse. It then reports res_cnt = remaining negative count and res_dst_last = arg_last. res_src holds the next source address minus one in copy mode, or the value in fill mode. Restarting with these operands completes the transfer.
- R7: On completion in copy mode, done pulses for one cycle. The engine then reports res_src = last source address + 1, res_dst_last = arg_last, res_cnt = 0.
- R8: On completion in fill mode, the engine reports res_src = arg_src, res_dst_last = arg_last, res_cnt = 0.
- R9: A zero count makes no memory request and no prefetch, and signals done.
- R10: At most one memory request is outstanding. A request keeps mem_req, mem_we and mem_addr steady until mem_gnt. No request is raised while a read awaits rvalid.
- R11: done and yielded are never high together. busy is low in any cycle where either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode_fill | input | 1 | 1 = fill, 0 = copy |
| arg_src | input | 16 | Copy: first source address minus one; fill: value |
| arg_last | input | 16 | Last destination address |
| arg_negcnt | input | 16 | Word count, negated |
| irq_pend | input | 1 | Interrupt pending, sampled between groups |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| pf_valid | output | 1 | Prefetch hint strobe |
| pf_addr | output | 16 | Prefetch hint address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on completion |
| yielded | output | 1 | One-cycle pulse on interrupt stop |
| res_src | output | 16 | Returned source/value operand |
| res_dst_last | output | 16 | Returned last destination operand |
| res_cnt | output | 16 | Returned negative remaining count |

## Verification
The result operands and the done or yielded pulse are registered together on the clock edge that closes the last group. They are therefore valid in the first cycle where busy is low. The bench polls at falling edges for done or yielded and reads every result in that same half-cycle. Memory contents, write counts and prefetch logs come from the bench's own memory model, which updates on the edge where mem_gnt is seen. They are compared only after the end pulse, so every write and hint of the operation has landed. A hint is recorded on the edge after its address appears, and a read answers one cycle after its grant.

// File: rtl/blk_mover_pkg.sv
package blk_mover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PF_A,
    ST_PF_B,
    ST_WORD,
    ST_RD,
    ST_RD_WAIT,
    ST_WR,
    ST_END
  } mv_state_t;
endpackage

// File: rtl/blk_mover_setup.sv
module blk_mover_setup #(
  parameter int W        = 16,
  parameter int GRP_LOG2 = 4
) (
  input  logic [W-1:0]        arg_src,
  input  logic [W-1:0]        arg_last,
  input  logic [W-1:0]        arg_negcnt,
  output logic [W-1:0]        init_src,
  output logic [W-1:0]        init_dst,
  output logic [GRP_LOG2:0]   init_len,
  output logic [W-1:0]        init_rem
);
  function automatic logic [W-1:0] first_dst(input logic [W-1:0] last, input logic [W-1:0] neg);
    return last + neg + W'(1);
  endfunction

  function automatic logic [GRP_LOG2-1:0] lead_len(input logic [W-1:0] neg);
    logic [W-1:0] pos;
    pos = W'(0) - neg;
    return pos[GRP_LOG2-1:0];
  endfunction

  logic [GRP_LOG2-1:0] len_w;

  always_comb begin
    len_w    = lead_len(arg_negcnt);
    init_src = arg_src + W'(1);
    init_dst = first_dst(arg_last, arg_negcnt);
    init_len = {1'b0, len_w};
    init_rem = arg_negcnt + W'(len_w);
  end
endmodule

// File: rtl/blk_mover_ctrl.sv
module blk_mover_ctrl
  import blk_mover_pkg::*;
#(
  parameter int W         = 16,
  parameter int GRP_LOG2  = 4,
  parameter int PF_GROUPS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode_fill,
  input  logic [W-1:0]       arg_src,
  input  logic [W-1:0]       arg_last,
  input  logic [W-1:0]       init_src,
  input  logic [W-1:0]       init_dst,
  input  logic [GRP_LOG2:0]  init_len,
  input  logic [W-1:0]       init_rem,
  input  logic               irq_pend,
  output logic               mem_req,
  output logic               mem_we,
  output logic [W-1:0]       mem_addr,
  output logic [W-1:0]       mem_wdata,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [W-1:0]       mem_rdata,
  output logic               pf_valid,
  output logic [W-1:0]       pf_addr,
  output logic               busy,
  output logic               done,
  output logic               yielded,
  output logic [W-1:0]       res_src,
  output logic [W-1:0]       res_dst_last,
  output logic [W-1:0]       res_cnt,
  output logic               rd_wait
);
  localparam int GRP = 1 << GRP_LOG2;
  localparam logic [W-1:0] PF_DIST = W'(PF_GROUPS * GRP);

  mv_state_t            state;
  logic                 fill_q;
  logic [W-1:0]         val_q, last_q, src_ptr, dst_ptr, rem_q, hold_q;
  logic [GRP_LOG2:0]    wcnt;
  logic                 more_groups;

  assign more_groups = (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fill_q  <= 1'b0;
      val_q   <= '0;
      last_q  <= '0;
      src_ptr <= '0;
      dst_ptr <= '0;
      rem_q   <= '0;
      hold_q  <= '0;
      wcnt    <= '0;
      res_src <= '0;
      res_cnt <= '0;
      done    <= 1'b0;
      yielded <= 1'b0;
    end else begin
      done    <= 1'b0;
      yielded <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          fill_q  <= mode_fill;
          val_q   <= arg_src;
          last_q  <= arg_last;
          src_ptr <= init_src;
          dst_ptr <= init_dst;
          rem_q   <= init_rem;
          wcnt    <= init_len;
          state   <= ST_PF_A;
        end
        ST_PF_A: state <= (more_groups && !fill_q) ? ST_PF_B : ST_WORD;
        ST_PF_B: state <= ST_WORD;
        ST_WORD: begin
          if (wcnt == '0)  state <= ST_END;
          else if (fill_q) state <= ST_WR;
          else             state <= ST_RD;
        end
        ST_RD: if (mem_gnt) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid) begin
          hold_q  <= mem_rdata;
          src_ptr <= src_ptr + W'(1);
          state   <= ST_WR;
        end
        ST_WR: if (mem_gnt) begin
          dst_ptr <= dst_ptr + W'(1);
          wcnt    <= wcnt - 1'b1;
          state   <= ST_WORD;
        end
        ST_END: begin
          if (!more_groups) begin
            res_src <= fill_q ? val_q : src_ptr;
            res_cnt <= '0;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else if (irq_pend) begin
            res_src <= fill_q ? val_q : (src_ptr - W'(1));
            res_cnt <= rem_q;
            yielded <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            rem_q <= rem_q + W'(GRP);
            wcnt  <= (GRP_LOG2+1)'(GRP);
            state <= ST_PF_A;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state != ST_IDLE);
    rd_wait      = (state == ST_RD_WAIT);
    mem_req      = (state == ST_RD) || (state == ST_WR);
    mem_we       = (state == ST_WR);
    mem_addr     = (state == ST_WR) ? dst_ptr : src_ptr;
    mem_wdata    = fill_q ? val_q : hold_q;
    pf_valid     = ((state == ST_PF_A) && more_groups) || (state == ST_PF_B);
    pf_addr      = ((state == ST_PF_A) && !fill_q) ? (src_ptr + PF_DIST) : (dst_ptr + PF_DIST);
    res_dst_last = last_q;
  end
endmodule

// File: rtl/blk_mover.sv
module blk_mover #(
  parameter int W         = 16,
  parameter int GRP_LOG2  = 4,
  parameter int PF_GROUPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode_fill,
  input  logic [W-1:0] arg_src,
  input  logic [W-1:0] arg_last,
  input  logic [W-1:0] arg_negcnt,
  input  logic         irq_pend,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_gnt,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata,
  output logic         pf_valid,
  output logic [W-1:0] pf_addr,
  output logic         busy,
  output logic         done,
  output logic         yielded,
  output logic [W-1:0] res_src,
  output logic [W-1:0] res_dst_last,
  output logic [W-1:0] res_cnt
);
  logic [W-1:0]      init_src, init_dst, init_rem;
  logic [GRP_LOG2:0] init_len;
  logic              rd_wait;

  blk_mover_setup #(.W(W), .GRP_LOG2(GRP_LOG2)) u_setup (
    .arg_src    (arg_src),
    .arg_last   (arg_last),
    .arg_negcnt (arg_negcnt),
    .init_src   (init_src),
    .init_dst   (init_dst),
    .init_len   (init_len),
    .init_rem   (init_rem)
  );

  blk_mover_ctrl #(.W(W), .GRP_LOG2(GRP_LOG2), .PF_GROUPS(PF_GROUPS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode_fill    (mode_fill),
    .arg_src      (arg_src),
    .arg_last     (arg_last),
    .init_src     (init_src),
    .init_dst     (init_dst),
    .init_len     (init_len),
    .init_rem     (init_rem),
    .irq_pend     (irq_pend),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_gnt      (mem_gnt),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .pf_valid     (pf_valid),
    .pf_addr      (pf_addr),
    .busy         (busy),
    .done         (done),
    .yielded      (yielded),
    .res_src      (res_src),
    .res_dst_last (res_dst_last),
    .res_cnt      (res_cnt),
    .rd_wait      (rd_wait)
  );
endmodule

// File: rtl/blk_mover_chk.sv
module blk_mover_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic         mem_gnt,
  input logic         pf_valid,
  input logic         busy,
  input logic         done,
  input logic         yielded,
  input logic [W-1:0] res_cnt,
  input logic         rd_wait
);
  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> !mem_req);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_end_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, yielded}) && !((done || yielded) && busy));

  assert_pf_in_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> busy);

  assert_done_zero_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_cnt == '0));

  assert_yield_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    yielded |-> (res_cnt != '0));
endmodule

bind blk_mover blk_mover_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_gnt  (mem_gnt),
  .pf_valid (pf_valid),
  .busy     (busy),
  .done     (done),
  .yielded  (yielded),
  .res_cnt  (res_cnt),
  .rd_wait  (rd_wait)
);

// File: tb/test_blk_mover.sv
module test_blk_mover;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode_fill = 1'b0, irq_pend = 1'b0;
  logic [15:0] arg_src = '0, arg_last = '0, arg_negcnt = '0;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, pf_valid, busy, done, yielded;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pf_addr, res_src, res_dst_last, res_cnt;

  int checks = 0, errors = 0;
  logic [15:0] mem [0:1023];
  logic        gnt_en;
  logic        rv_q;
  logic [15:0] rd_q;
  int          wr_cnt, rd_cnt, pf_cnt;
  logic [15:0] pf_log [0:3];
  logic        rd_before_wr_bad;
  logic        rd_seen;

  always #2 clk = ~clk;

  assign mem_gnt    = mem_req && gnt_en;
  assign mem_rvalid = rv_q;
  assign mem_rdata  = rd_q;

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 41) ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      gnt_en <= 1'b0; rv_q <= 1'b0; rd_q <= '0;
      wr_cnt <= 0; rd_cnt <= 0; pf_cnt <= 0;
      rd_seen <= 1'b0; rd_before_wr_bad <= 1'b0;
    end else begin
      gnt_en <= ~gnt_en;
      rv_q   <= mem_req && mem_gnt && !mem_we;
      rd_q   <= mem[mem_addr[9:0]];
      if (rv_q) rd_seen <= 1'b1;
      if (mem_req && mem_gnt && !mem_we) rd_cnt <= rd_cnt + 1;
      if (mem_req && mem_gnt && mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        if (!mode_fill) begin
          if (!rd_seen) rd_before_wr_bad <= 1'b1;
          rd_seen <= 1'b0;
        end
      end
      if (pf_valid) begin
        pf_log[pf_cnt[1:0]] <= pf_addr;
        pf_cnt <= pf_cnt + 1;
      end
    end
  end

  blk_mover i_blk_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_fill(mode_fill),
    .arg_src(arg_src), .arg_last(arg_last), .arg_negcnt(arg_negcnt),
    .irq_pend(irq_pend), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pf_valid(pf_valid),
    .pf_addr(pf_addr), .busy(busy), .done(done), .yielded(yielded),
    .res_src(res_src), .res_dst_last(res_dst_last), .res_cnt(res_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // start one operation and wait for its end pulse; returns 1 for done, 0 for yielded
  task automatic run_op(input bit fill, input logic [15:0] s, input logic [15:0] l,
                        input logic [15:0] n, output bit was_done,
                        output int wb, output int pb);
    int guard;
    @(negedge clk);
    wb = wr_cnt; pb = pf_cnt;
    mode_fill = fill; arg_src = s; arg_last = l; arg_negcnt = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!(done || yielded) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 3000, "R11 watchdog end pulse", guard, 3000);
    was_done = done;
    chk(!busy, "R11 busy low at end", busy, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !yielded, "R11 reset idle", {busy, done, yielded}, 0);
    chk(!mem_req && !pf_valid, "R10 reset no request", {mem_req, pf_valid}, 0);
  endtask

  task automatic t_copy5;
    bit d; int wb, pb, bad;
    run_op(0, 16'd99, 16'd304, 16'hFFFB, d, wb, pb);
    chk(d, "R7 copy5 done", d, 1);
    bad = 0;
    for (int k = 0; k < 5; k++) if (mem[300+k] !== pat(100+k)) bad++;
    chk(bad == 0, "R1 R2 copy5 data placement", bad, 0);
    chk(mem[299] === pat(299) && mem[305] === pat(305), "R1 copy5 neighbours untouched", mem[305], pat(305));
    chk(wr_cnt - wb == 5, "R4 copy5 writes", wr_cnt - wb, 5);
    chk(pf_cnt == pb, "R5 copy5 no prefetch on final group", pf_cnt - pb, 0);
    chk(res_src == 16'd105 && res_dst_last == 16'd304 && res_cnt == 0, "R7 copy5 results", res_src, 105);
    chk(!rd_before_wr_bad, "R2 read precedes write", rd_before_wr_bad, 0);
  endtask

  task automatic t_copy37;
    bit d; int wb, pb, bad;
    run_op(0, 16'd199, 16'd436, 16'hFFDB, d, wb, pb);
    bad = 0;
    for (int k = 0; k < 37; k++) if (mem[400+k] !== pat(200+k)) bad++;
    chk(d && bad == 0, "R2 copy37 data", bad, 0);
    chk(pf_cnt - pb == 4, "R5 copy37 prefetch count", pf_cnt - pb, 4);
    chk(pf_log[pb[1:0]] == 16'd232, "R5 copy37 source hint", pf_log[pb[1:0]], 232);
    chk(pf_log[2'(pb + 1)] == 16'd432, "R5 copy37 dest hint", pf_log[2'(pb + 1)], 432);
    chk(res_src == 16'd237 && res_cnt == 0 && res_dst_last == 16'd436, "R7 copy37 results", res_src, 237);
  endtask

  task automatic t_fill20;
    bit d; int wb, pb, bad, rb;
    rb = rd_cnt;
    run_op(1, 16'hA5A5, 16'd619, 16'hFFEC, d, wb, pb);
    bad = 0;
    for (int k = 0; k < 20; k++) if (mem[600+k] !== 16'hA5A5) bad++;
    chk(d && bad == 0, "R3 fill20 data", bad, 0);
    chk(mem[620] === pat(620) && rd_cnt == rb, "R3 fill20 bounds and no reads", rd_cnt - rb, 0);
    chk(pf_cnt - pb == 1 && pf_log[pb[1:0]] == 16'd632, "R5 fill20 single dest hint", pf_log[pb[1:0]], 632);
    chk(res_src == 16'hA5A5 && res_dst_last == 16'd619 && res_cnt == 0, "R8 fill20 results", res_src, 16'hA5A5);
  endtask

  task automatic t_zero;
    bit d; int wb, pb, rb;
    rb = rd_cnt;
    run_op(0, 16'd50, 16'd70, 16'h0000, d, wb, pb);
    chk(d && wr_cnt == wb && rd_cnt == rb, "R9 zero count no access", wr_cnt - wb, 0);
    chk(pf_cnt == pb && res_cnt == 0, "R9 zero count no prefetch", pf_cnt - pb, 0);
  endtask

  task automatic t_exact16;
    bit d; int wb, pb, bad;
    run_op(0, 16'd699, 16'd815, 16'hFFF0, d, wb, pb);
    bad = 0;
    for (int k = 0; k < 16; k++) if (mem[800+k] !== pat(700+k)) bad++;
    chk(d && bad == 0 && wr_cnt - wb == 16, "R4 count16 empty lead group", wr_cnt - wb, 16);
    chk(pf_cnt - pb == 2 && pf_log[pb[1:0]] == 16'd732, "R5 count16 hints", pf_log[pb[1:0]], 732);
  endtask

  task automatic t_irq;
    bit d; int wb, pb, bad;
    irq_pend = 1'b1;
    run_op(0, 16'd99, 16'd936, 16'hFFDB, d, wb, pb);
    chk(!d, "R6 interrupt yields", d, 0);
    chk(wr_cnt - wb == 5, "R4 R6 only lead group moved", wr_cnt - wb, 5);
    chk(res_cnt == 16'hFFE0, "R6 remaining count", res_cnt, 16'hFFE0);
    chk(res_src == 16'd104 && res_dst_last == 16'd936, "R6 restart operands", res_src, 104);
    chk(mem[905] === pat(905), "R6 no write past group", mem[905], pat(905));
    irq_pend = 1'b0;
    run_op(0, res_src, res_dst_last, res_cnt, d, wb, pb);
    bad = 0;
    for (int k = 0; k < 37; k++) if (mem[900+k] !== pat(100+k)) bad++;
    chk(d && bad == 0 && wr_cnt - wb == 32, "R6 resumed transfer completes", bad, 0);
    chk(res_src == 16'd137 && res_cnt == 0, "R7 resumed results", res_src, 137);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_copy5;
    t_copy37;
    t_fill20;
    t_zero;
    t_exact16;
    t_irq;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule